// File: doc/BRIEF.md
# Temperature-Aware Refresh Scheduler

This block paces auto-refresh requests for a DDR2 memory controller. A down-counter, sized from the clock period given in picoseconds, marks the end of each average refresh interval. It uses the normal interval while the case is cool and half that interval while a high-temperature flag is set. Each expiry adds one to a count of owed refreshes. The request output stays high while that count is nonzero, and the command arbiter retires one owed refresh per grant. When the controller has fallen the full allowed number of refreshes behind, an urgent flag tells the arbiter to give refresh priority.

The block also guards self-refresh entry in the hot range. While the hot flag is set, it drives a bit telling the controller that the high-temperature self-refresh option must be programmed into the extended mode register. It blocks any self-refresh entry request until the controller confirms that this write has been done. The confirmation is forgotten as soon as the hot condition ends, so each new hot period needs a fresh write.

Top module: `refresh_sched`

## Requirements
- R1: While and after reset, `pend_cnt_o` is 0, and `ref_req_o`, `urgent_o` and `hot_sr_o` are low.
- R2: The interval length in cycles is floor(interval_ps / CLK_PS), with a minimum of 1. After reset is released, the first owed refresh appears on the clock edge numbered NORM_CYC.
- R3: `ref_req_o` is high exactly when `pend_cnt_o` is nonzero. With no grant, it stays high and the count does not fall.
- R4: On each edge with `ref_gnt_i` high and a nonzero count, the count drops by one. An interval expiring on the same edge is then added to the result.
- R5: A grant while the count is zero has no effect, so the count stays 0.
- R6: `urgent_o` is high exactly when `pend_cnt_o` equals MAX_POSTPONE.
- R7: An interval that expires while the count is already MAX_POSTPONE after grants is dropped, so the count never exceeds MAX_POSTPONE.
- R8: On each expiry the counter reloads with the hot interval if `hot_i` is high on that edge, and with the normal interval otherwise. A change of `hot_i` in mid-interval does not shorten or lengthen the interval already running.
- R9: `hot_sr_o` equals `hot_i` delayed by one clock edge.
- R10: While `hot_sr_o` is low, `sr_ok_o` equals `sr_req_i`.
- R11: While `hot_sr_o` is high, `sr_ok_o` stays low until `mr_done_i` has been seen high on an edge with `hot_sr_o` high. After that, `sr_ok_o` follows `sr_req_i`.
- R12: Any edge with `hot_sr_o` low clears the confirmation, so a later hot period needs a new `mr_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hot_i | input | 1 | Case temperature is in the high range |
| ref_gnt_i | input | 1 | Arbiter accepts one refresh this cycle |
| sr_req_i | input | 1 | Controller asks to enter self-refresh |
| mr_done_i | input | 1 | High-temperature self-refresh mode bit has been written |
| ref_req_o | output | 1 | At least one refresh is owed |
| pend_cnt_o | output | $clog2(MAX_POSTPONE+1) | Number of owed refreshes |
| urgent_o | output | 1 | Owed count has reached its limit |
| hot_sr_o | output | 1 | High-temperature self-refresh mode bit must be set |
| sr_ok_o | output | 1 | Self-refresh entry allowed |

## Verification
A wrong interval counter shows up as an owed-count step on the wrong edge. The first such error appears within one interval, and a reload that uses the wrong temperature source shows within the following interval. A wrong postpone count is visible on the same cycle through the request and urgent outputs, and it stays wrong until grants drain it. A stale self-refresh confirmation shows up as a premature `sr_ok_o` on the first hot cycle after a cool period.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  function automatic int unsigned ps_to_cyc(int unsigned ps, int unsigned clk_ps);
    int unsigned c;
    c = ps / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rs_interval_timer.sv
module rs_interval_timer #(
  parameter int unsigned NORM_CYC = 1950,
  parameter int unsigned HOT_CYC  = 975,
  parameter int unsigned TW       = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hot_i,
  output logic tick_o
);
  localparam logic [TW-1:0] NORM_LD = TW'(NORM_CYC - 1);
  localparam logic [TW-1:0] HOT_LD  = TW'(HOT_CYC - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  // reload choice sampled only at expiry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= NORM_LD;
    else if (tick_o) cnt_q <= hot_i ? HOT_LD : NORM_LD;
    else             cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/rs_postpone_ctr.sv
module rs_postpone_ctr #(
  parameter int unsigned MAX_POSTPONE = 8,
  parameter int unsigned CW           = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          gnt_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] FULL = CW'(MAX_POSTPONE);

  logic [CW-1:0] cnt_q, after_gnt, cnt_d;

  // grant retires first, then expiry adds with saturation
  always_comb begin
    after_gnt = (gnt_i && cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    cnt_d     = (tick_i && after_gnt != FULL) ? after_gnt + 1'b1 : after_gnt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rs_hot_guard.sv
module rs_hot_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hot_i,
  input  logic sr_req_i,
  input  logic mr_done_i,
  output logic hot_sr_o,
  output logic sr_ok_o
);
  logic hot_q, conf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hot_q  <= 1'b0;
      conf_q <= 1'b0;
    end else begin
      hot_q  <= hot_i;
      conf_q <= hot_q & (conf_q | mr_done_i);
    end
  end

  assign hot_sr_o = hot_q;
  assign sr_ok_o  = sr_req_i & (~hot_q | conf_q);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned CLK_PS       = 4000,
  parameter int unsigned NORM_PS      = 7_800_000,
  parameter int unsigned HOT_PS       = 3_900_000,
  parameter int unsigned MAX_POSTPONE = 8,
  localparam int unsigned CW          = $clog2(MAX_POSTPONE + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hot_i,
  input  logic          ref_gnt_i,
  input  logic          sr_req_i,
  input  logic          mr_done_i,
  output logic          ref_req_o,
  output logic [CW-1:0] pend_cnt_o,
  output logic          urgent_o,
  output logic          hot_sr_o,
  output logic          sr_ok_o
);
  import refresh_pkg::*;

  localparam int unsigned NORM_CYC = ps_to_cyc(NORM_PS, CLK_PS);
  localparam int unsigned HOT_CYC  = ps_to_cyc(HOT_PS, CLK_PS);
  localparam int unsigned TW       = $clog2(max_u(NORM_CYC, HOT_CYC) + 1);

  logic tick;

  rs_interval_timer #(.NORM_CYC(NORM_CYC), .HOT_CYC(HOT_CYC), .TW(TW)) u_timer (
    .clk_i, .rst_ni, .hot_i, .tick_o(tick)
  );

  rs_postpone_ctr #(.MAX_POSTPONE(MAX_POSTPONE), .CW(CW)) u_pend (
    .clk_i, .rst_ni, .tick_i(tick), .gnt_i(ref_gnt_i), .cnt_o(pend_cnt_o)
  );

  rs_hot_guard u_guard (
    .clk_i, .rst_ni, .hot_i, .sr_req_i, .mr_done_i, .hot_sr_o, .sr_ok_o
  );

  assign ref_req_o = (pend_cnt_o != '0);
  assign urgent_o  = (pend_cnt_o == CW'(MAX_POSTPONE));
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int unsigned MAX_POSTPONE = 8,
  parameter int unsigned CW           = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hot_i,
  input logic          ref_gnt_i,
  input logic          ref_req_o,
  input logic [CW-1:0] pend_cnt_o,
  input logic          hot_sr_o,
  input logic          sr_ok_o
);
  // R3
  req_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o && !ref_gnt_i |=> ref_req_o);

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_cnt_o <= CW'(MAX_POSTPONE));

  // R4
  gnt_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o && ref_gnt_i |=> pend_cnt_o <= $past(pend_cnt_o));

  // R5
  idle_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_cnt_o == '0 && ref_gnt_i |=> pend_cnt_o <= CW'(1));

  // R9
  cool_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hot_i |=> !hot_sr_o);

  // R11
  fresh_hot_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hot_sr_o) |-> !sr_ok_o);
endmodule

bind refresh_sched refresh_sched_chk #(.MAX_POSTPONE(MAX_POSTPONE), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hot_i(hot_i), .ref_gnt_i(ref_gnt_i),
  .ref_req_o(ref_req_o), .pend_cnt_o(pend_cnt_o), .hot_sr_o(hot_sr_o), .sr_ok_o(sr_ok_o)
);

// File: tb/refresh_sched_tb.sv
`timescale 1ns/1ps
module refresh_sched_tb;
  localparam int NORM = 10, HOT = 5, MAXP = 8, CW = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic hot_i = 0, ref_gnt_i = 0, sr_req_i = 0, mr_done_i = 0;
  logic ref_req_o, urgent_o, hot_sr_o, sr_ok_o;
  logic [CW-1:0] pend_cnt_o;

  always #2 clk = ~clk;

  refresh_sched #(.CLK_PS(4000), .NORM_PS(NORM*4000), .HOT_PS(HOT*4000), .MAX_POSTPONE(MAXP)) u_dut (
    .clk_i(clk), .rst_ni, .hot_i, .ref_gnt_i, .sr_req_i, .mr_done_i,
    .ref_req_o, .pend_cnt_o, .urgent_o, .hot_sr_o, .sr_ok_o
  );

  int n_chk = 0, n_fail = 0, e = 0, next_tick = NORM, m_pend = 0;
  bit m_hot = 0, m_conf = 0, done = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, e, act, exp);
    end
  endtask

  task automatic cyc(bit h, bit g, bit s, bit m, string tag);
    hot_i = h; ref_gnt_i = g; sr_req_i = s; mr_done_i = m;
    @(posedge clk);
    e++;
    if (g && m_pend != 0) m_pend--;
    if (e == next_tick) begin
      if (m_pend != MAXP) m_pend++;
      next_tick += h ? HOT : NORM;
    end
    m_conf = m_hot && (m_conf || m);
    m_hot  = h;
    @(negedge clk);
    chk(tag, pend_cnt_o, m_pend);
    chk("R3", ref_req_o, m_pend != 0);
    chk("R6", urgent_o, m_pend == MAXP);
    chk("R9", hot_sr_o, m_hot);
    chk(m_hot ? "R11" : "R10", sr_ok_o, s && (!m_hot || m_conf));
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", pend_cnt_o, 0); chk("R1", ref_req_o, 0);
    chk("R1", urgent_o, 0);   chk("R1", hot_sr_o, 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 9; i++) cyc(0, 0, 0, 0, "R2");
    chk("R2", pend_cnt_o, 0);
    cyc(0, 0, 0, 0, "R2");
    chk("R2", pend_cnt_o, 1);
    for (int i = 0; i < 15; i++) cyc(0, 0, i[0], 0, "R3");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, "R4");
    cyc(0, 1, 1, 0, "R5");
    chk("R5", pend_cnt_o, 0);
    for (int i = 0; i < 97; i++) cyc(0, 0, i[1], 0, "R7");
    chk("R7", pend_cnt_o, MAXP);
    cyc(0, 1, 0, 0, "R4");
    // hot rises mid-interval: running interval keeps normal length
    for (int i = 0; i < 14; i++) cyc(1, i[0], 1, 0, "R8");
    cyc(1, 0, 1, 1, "R11");
    for (int i = 0; i < 12; i++) cyc(1, 1, 1, 0, "R8");
    cyc(0, 0, 1, 0, "R12");
    for (int i = 0; i < 4; i++) cyc(0, 0, i[0], 0, "R10");
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, 0, "R12");
    cyc(1, 0, 1, 1, "R11");
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, 0, "R11");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule